// File: doc/BRIEF.md
# Out-of-Order Dispatch and Retire Controller

This block sits between an in-order queue of decoded instructions and the out-of-order back end. Each cycle it looks at up to `MAX_W` instructions at the head of the queue and decides how many of them leave the queue as one dispatch group. An instruction joins the group only if four conditions hold: the group has not reached the width limit, the reorder buffer has room for all of its micro-operations, the rename register pool can cover its destination registers, and its target scheduler or memory queue is not reporting full. An optional per-instruction flag forces an instruction to dispatch on its own. The first instruction that fails a check blocks all younger ones in that cycle.

Dispatched instructions take consecutive reorder-buffer slots, one slot per micro-operation. The first slot's index is the instruction's tag. Execution units report completion by tag. The controller retires completed instructions strictly from the oldest end, up to the effective width per cycle, and returns their slots and rename registers to the free pools. Six stall counters record why a group was cut short. Two histograms record how many instructions were dispatched and how many were retired in each cycle.

Top module: `dispatch_retire_unit`

## Requirements
- R1: Only a contiguous run of valid slots starting at slot 0 is dispatched; `dispCount` is the length of that run, and slot k's tag equals the tail index plus the micro-op counts of slots 0..k-1 (modulo the buffer depth).
- R2: At most the effective width is dispatched per cycle; `cfgWidth` = 0 selects the default width `DEF_W` (2), and values above `MAX_W` (4) are clamped to `MAX_W`.
- R3: Each instruction takes as many buffer slots as its micro-op count (1..3); an instruction that needs more slots than are free is not dispatched and no younger slot is dispatched in the same cycle.
- R4: With `cfgRegLimit` non-zero, registers in use plus the registers requested by the group never exceed the limit; with `cfgRegLimit` = 0 renaming never blocks dispatch.
- R5: Kind code 0 (integer) needs `schedFull[0]` low, kind 1 (floating point) needs `schedFull[1]` low, kinds 2 (load) and 3 (store) need `schedFull[2]` low; a load also needs `lqFull` low and a store needs `sqFull` low, and neither queue flag affects the other kind.
- R6: A slot with `inSolo` set dispatches only as slot 0, and nothing follows it in the same group.
- R7: A reported completion never retires an instruction before the cycle after the report; retirement takes only completed instructions from the oldest end, stops at the first incomplete one, and is capped at the effective width.
- R8: On retirement the instruction's buffer slots and rename registers are returned, so `robUsed` and `regsInUse` drop by its micro-op and register counts.
- R9: When a valid slot is rejected below the width limit, exactly one stall counter increments, chosen by the first failed check in the order registers (field 0), buffer (1), scheduler (2), load queue (3), store queue (4), solo rule (5); `stallCnt` field c sits at bits [c*CNT_W +: CNT_W].
- R10: Each cycle after reset, histogram bin n of `dispHist` (or `retHist`) increments when n instructions were dispatched (or retired); bin n sits at bits [n*CNT_W +: CNT_W].
- R11: After reset the buffer is empty, no registers are in use, and all counters and histogram bins are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWidth | input | 3 | Dispatch/retire width; 0 = default |
| cfgRegLimit | input | 7 | Rename register limit; 0 = unlimited |
| inValid | input | 4 | Queue head slot valid, slot 0 oldest |
| inUops | input | 8 | Per-slot micro-op count (1..3), 2 bits each |
| inRegs | input | 8 | Per-slot destination register count, 2 bits each |
| inKind | input | 8 | Per-slot kind code, 2 bits each |
| inSolo | input | 4 | Per-slot must-dispatch-alone flag |
| schedFull | input | 3 | Scheduler full flags |
| lqFull | input | 1 | Load queue full |
| sqFull | input | 1 | Store queue full |
| wbValid | input | 1 | Completion report valid |
| wbTag | input | 4 | Tag of completed instruction |
| dispCount | output | 4 | Slots taken from the queue this cycle |
| dispTag | output | 16 | Per-slot tag, 4 bits each |
| retireCount | output | 4 | Instructions retiring this cycle |
| robUsed | output | 5 | Occupied buffer slots |
| regsInUse | output | 7 | Allocated rename registers |
| stallCnt | output | 96 | Six stall counters |
| dispHist | output | 80 | Dispatch-count histogram |
| retHist | output | 80 | Retire-count histogram |

## Verification
The embedded assertions check the following on every cycle: the group never exceeds the effective width, buffer occupancy stays within the depth, a granted group never oversubscribes a finite register limit, completions target live slots, retirement starts only from a completed head, and exactly one stall cause and one histogram bin advance per cycle. Other behaviours can only be shown by the directed scenarios. These are which slot blocks the group and why, the precedence among simultaneous stall causes, the no-bypass rule on a full buffer, the clamping of the width setting, and the exact cycle and count of in-order retirement after out-of-order completions.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int NUM_CAUSES = 6;
  localparam int NUM_SCHED  = 3;
  localparam int N_FIELD_W  = 4;

  typedef enum logic [2:0] {
    CAUSE_REG   = 3'd0,
    CAUSE_ROB   = 3'd1,
    CAUSE_SCHED = 3'd2,
    CAUSE_LQ    = 3'd3,
    CAUSE_SQ    = 3'd4,
    CAUSE_GROUP = 3'd5
  } stallCause_e;

  localparam logic [1:0] KIND_INT   = 2'd0;
  localparam logic [1:0] KIND_FP    = 2'd1;
  localparam logic [1:0] KIND_LOAD  = 2'd2;
  localparam logic [1:0] KIND_STORE = 2'd3;

  typedef struct packed {
    logic [N_FIELD_W-1:0] dispN;
    logic                 stall;
    stallCause_e          cause;
  } dispStrobe_t;
endpackage

// File: rtl/drc_dispatch_ctl.sv
module drc_dispatch_ctl
  import drc_pkg::*;
#(
  parameter int MAX_W  = 4,
  parameter int DEF_W  = 2,
  parameter int DEPTH  = 16,
  parameter int UOP_W  = 2,
  parameter int REG_W  = 2,
  parameter int PREG_W = 7,
  parameter int CFGW_W = 3,
  parameter int OCC_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CFGW_W-1:0]       cfgWidth,
  input  logic [PREG_W-1:0]       cfgRegLimit,
  input  logic [MAX_W-1:0]        inValid,
  input  logic [MAX_W*UOP_W-1:0]  inUops,
  input  logic [MAX_W*REG_W-1:0]  inRegs,
  input  logic [MAX_W*2-1:0]      inKind,
  input  logic [MAX_W-1:0]        inSolo,
  input  logic [NUM_SCHED-1:0]    schedFull,
  input  logic                    lqFull,
  input  logic                    sqFull,
  input  logic [OCC_W-1:0]        robUsed,
  input  logic [PREG_W-1:0]       regsUsed,
  output logic [CFGW_W-1:0]       effWidth,
  output dispStrobe_t             strobe
);

  always_comb begin
    if (cfgWidth == '0)
      effWidth = CFGW_W'(DEF_W);
    else if (int'(cfgWidth) > MAX_W)
      effWidth = CFGW_W'(MAX_W);
    else
      effWidth = cfgWidth;
  end

  // Walk the head slots oldest first; the first rejected slot ends the group.
  always_comb begin
    int          uSum, rSum, n, u, r;
    logic        go, regOk, robOk, schOk, lqOk, sqOk, grpOk;
    logic [1:0]  kd;
    strobe       = '0;
    strobe.cause = CAUSE_REG;
    go   = 1'b1;
    n    = 0;
    uSum = 0;
    rSum = 0;
    for (int k = 0; k < MAX_W; k++) begin
      u  = int'(inUops[k*UOP_W +: UOP_W]);
      r  = int'(inRegs[k*REG_W +: REG_W]);
      kd = inKind[k*2 +: 2];
      regOk = (cfgRegLimit == '0) ||
              (int'(regsUsed) + rSum + r <= int'(cfgRegLimit));
      robOk = (int'(robUsed) + uSum + u <= DEPTH);
      case (kd)
        KIND_INT: schOk = !schedFull[0];
        KIND_FP:  schOk = !schedFull[1];
        default:  schOk = !schedFull[2];
      endcase
      lqOk  = !(kd == KIND_LOAD && lqFull);
      sqOk  = !(kd == KIND_STORE && sqFull);
      grpOk = (k == 0) || (!inSolo[k] && !inSolo[0]);
      if (go) begin
        if (k >= int'(effWidth) || !inValid[k]) begin
          go = 1'b0;
        end else if (!(regOk && robOk && schOk && lqOk && sqOk && grpOk)) begin
          go = 1'b0;
          strobe.stall = 1'b1;
          if (!regOk)      strobe.cause = CAUSE_REG;
          else if (!robOk) strobe.cause = CAUSE_ROB;
          else if (!schOk) strobe.cause = CAUSE_SCHED;
          else if (!lqOk)  strobe.cause = CAUSE_LQ;
          else if (!sqOk)  strobe.cause = CAUSE_SQ;
          else             strobe.cause = CAUSE_GROUP;
        end else begin
          n    = n + 1;
          uSum = uSum + u;
          rSum = rSum + r;
        end
      end
    end
    strobe.dispN = N_FIELD_W'(n);
  end

  a_r2_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(strobe.dispN) <= int'(effWidth));

  a_r1_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.dispN != '0 |-> inValid[0]);

endmodule

// File: rtl/drc_rob_dp.sv
module drc_rob_dp
  import drc_pkg::*;
#(
  parameter int MAX_W  = 4,
  parameter int DEPTH  = 16,
  parameter int UOP_W  = 2,
  parameter int REG_W  = 2,
  parameter int PREG_W = 7,
  parameter int CFGW_W = 3,
  parameter int IDX_W  = 4,
  parameter int OCC_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dispStrobe_t             strobe,
  input  logic [CFGW_W-1:0]       effWidth,
  input  logic [PREG_W-1:0]       cfgRegLimit,
  input  logic [MAX_W*UOP_W-1:0]  inUops,
  input  logic [MAX_W*REG_W-1:0]  inRegs,
  input  logic                    wbValid,
  input  logic [IDX_W-1:0]        wbTag,
  output logic [OCC_W-1:0]        robUsed,
  output logic [PREG_W-1:0]       regsUsed,
  output logic [MAX_W*IDX_W-1:0]  dispTag,
  output logic [N_FIELD_W-1:0]    retN
);

  logic [IDX_W-1:0] headPtr, tailPtr;
  logic [DEPTH-1:0] entVld, entDone;
  logic [UOP_W-1:0] entUops [DEPTH];
  logic [REG_W-1:0] entRegs [DEPTH];
  logic [IDX_W-1:0] tagArr  [MAX_W];
  logic [IDX_W-1:0] relHead [DEPTH];
  logic [IDX_W-1:0] relTail [DEPTH];
  int dispU, dispR, retU, retR;

  // Tags and group totals for the granted slots.
  always_comb begin
    int off;
    off   = 0;
    dispU = 0;
    dispR = 0;
    for (int k = 0; k < MAX_W; k++) begin
      tagArr[k] = tailPtr + IDX_W'(off);
      dispTag[k*IDX_W +: IDX_W] = tagArr[k];
      if (k < int'(strobe.dispN)) begin
        dispU = dispU + int'(inUops[k*UOP_W +: UOP_W]);
        dispR = dispR + int'(inRegs[k*REG_W +: REG_W]);
      end
      off = off + int'(inUops[k*UOP_W +: UOP_W]);
    end
  end

  // In-order retire walk from the head.
  always_comb begin
    int               off, rn;
    logic             go;
    logic [IDX_W-1:0] pos;
    off  = 0;
    rn   = 0;
    go   = 1'b1;
    retU = 0;
    retR = 0;
    for (int k = 0; k < MAX_W; k++) begin
      pos = headPtr + IDX_W'(off);
      if (go) begin
        if (k >= int'(effWidth) || off >= int'(robUsed) || !entDone[pos]) begin
          go = 1'b0;
        end else begin
          rn   = rn + 1;
          retU = retU + int'(entUops[pos]);
          retR = retR + int'(entRegs[pos]);
          off  = off + int'(entUops[pos]);
        end
      end
    end
    retN = N_FIELD_W'(rn);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      relHead[i] = IDX_W'(i) - headPtr;
      relTail[i] = IDX_W'(i) - tailPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      robUsed  <= '0;
      regsUsed <= '0;
      entVld   <= '0;
      entDone  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entUops[i] <= '0;
        entRegs[i] <= '0;
      end
    end else begin
      robUsed  <= robUsed + OCC_W'(dispU) - OCC_W'(retU);
      regsUsed <= regsUsed + PREG_W'(dispR) - PREG_W'(retR);
      headPtr  <= headPtr + IDX_W'(retU);
      tailPtr  <= tailPtr + IDX_W'(dispU);
      for (int i = 0; i < DEPTH; i++) begin
        if (int'(relHead[i]) < retU) begin
          entVld[i]  <= 1'b0;
          entDone[i] <= 1'b0;
        end
        if (int'(relTail[i]) < dispU) begin
          entVld[i]  <= 1'b1;
          entDone[i] <= 1'b0;
        end
      end
      for (int k = 0; k < MAX_W; k++) begin
        if (k < int'(strobe.dispN)) begin
          entUops[tagArr[k]] <= inUops[k*UOP_W +: UOP_W];
          entRegs[tagArr[k]] <= inRegs[k*REG_W +: REG_W];
        end
      end
      if (wbValid) entDone[wbTag] <= 1'b1;
    end
  end

  a_r3_rob_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(robUsed) <= DEPTH);

  a_r4_reg_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgRegLimit != '0 && strobe.dispN != '0) |->
      int'(regsUsed) + dispR <= int'(cfgRegLimit));

  a_r7_wb_live: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> entVld[wbTag]);

  a_r7_head_done: assert property (@(posedge clk) disable iff (!rst_n)
    retN != '0 |-> (entDone[headPtr] && entVld[headPtr]));

endmodule

// File: rtl/drc_stats.sv
module drc_stats
  import drc_pkg::*;
#(
  parameter int MAX_W = 4,
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  dispStrobe_t                   strobe,
  input  logic [N_FIELD_W-1:0]          retN,
  output logic [NUM_CAUSES*CNT_W-1:0]   stallCnt,
  output logic [(MAX_W+1)*CNT_W-1:0]    dispHist,
  output logic [(MAX_W+1)*CNT_W-1:0]    retHist
);

  genvar c, n;
  generate
    for (c = 0; c < NUM_CAUSES; c++) begin : g_stall
      always_ff @(posedge clk) begin
        if (!rst_n)
          stallCnt[c*CNT_W +: CNT_W] <= '0;
        else if (strobe.stall && int'(strobe.cause) == c)
          stallCnt[c*CNT_W +: CNT_W] <= stallCnt[c*CNT_W +: CNT_W] + 1'b1;
      end
    end
    for (n = 0; n <= MAX_W; n++) begin : g_hist
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          dispHist[n*CNT_W +: CNT_W] <= '0;
          retHist[n*CNT_W +: CNT_W]  <= '0;
        end else begin
          if (int'(strobe.dispN) == n)
            dispHist[n*CNT_W +: CNT_W] <= dispHist[n*CNT_W +: CNT_W] + 1'b1;
          if (int'(retN) == n)
            retHist[n*CNT_W +: CNT_W] <= retHist[n*CNT_W +: CNT_W] + 1'b1;
        end
      end
    end
  endgenerate

  int stallSum, dispSum, retSum;
  always_comb begin
    stallSum = 0;
    dispSum  = 0;
    retSum   = 0;
    for (int i = 0; i < NUM_CAUSES; i++) stallSum = stallSum + int'(stallCnt[i*CNT_W +: CNT_W]);
    for (int i = 0; i <= MAX_W; i++) begin
      dispSum = dispSum + int'(dispHist[i*CNT_W +: CNT_W]);
      retSum  = retSum + int'(retHist[i*CNT_W +: CNT_W]);
    end
  end

  a_r9_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stallSum == $past(stallSum) + ($past(strobe.stall) ? 1 : 0));

  a_r10_one_bin: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dispSum == $past(dispSum) + 1 && retSum == $past(retSum) + 1));

endmodule

// File: rtl/dispatch_retire_unit.sv
module dispatch_retire_unit
  import drc_pkg::*;
#(
  parameter int MAX_W  = 4,
  parameter int DEF_W  = 2,
  parameter int DEPTH  = 16,
  parameter int UOP_W  = 2,
  parameter int REG_W  = 2,
  parameter int PREG_W = 7,
  parameter int CNT_W  = 16,
  localparam int CFGW_W = $clog2(MAX_W + 1),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CFGW_W-1:0]             cfgWidth,
  input  logic [PREG_W-1:0]             cfgRegLimit,
  input  logic [MAX_W-1:0]              inValid,
  input  logic [MAX_W*UOP_W-1:0]        inUops,
  input  logic [MAX_W*REG_W-1:0]        inRegs,
  input  logic [MAX_W*2-1:0]            inKind,
  input  logic [MAX_W-1:0]              inSolo,
  input  logic [NUM_SCHED-1:0]          schedFull,
  input  logic                          lqFull,
  input  logic                          sqFull,
  input  logic                          wbValid,
  input  logic [IDX_W-1:0]              wbTag,
  output logic [N_FIELD_W-1:0]          dispCount,
  output logic [MAX_W*IDX_W-1:0]        dispTag,
  output logic [N_FIELD_W-1:0]          retireCount,
  output logic [OCC_W-1:0]              robUsed,
  output logic [PREG_W-1:0]             regsInUse,
  output logic [NUM_CAUSES*CNT_W-1:0]   stallCnt,
  output logic [(MAX_W+1)*CNT_W-1:0]    dispHist,
  output logic [(MAX_W+1)*CNT_W-1:0]    retHist
);

  dispStrobe_t           strobe;
  logic [CFGW_W-1:0]     effWidth;
  logic [N_FIELD_W-1:0]  retN;

  drc_dispatch_ctl #(
    .MAX_W(MAX_W), .DEF_W(DEF_W), .DEPTH(DEPTH), .UOP_W(UOP_W),
    .REG_W(REG_W), .PREG_W(PREG_W), .CFGW_W(CFGW_W), .OCC_W(OCC_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfgWidth(cfgWidth), .cfgRegLimit(cfgRegLimit),
    .inValid(inValid), .inUops(inUops), .inRegs(inRegs), .inKind(inKind),
    .inSolo(inSolo), .schedFull(schedFull), .lqFull(lqFull), .sqFull(sqFull),
    .robUsed(robUsed), .regsUsed(regsInUse), .effWidth(effWidth), .strobe(strobe)
  );

  drc_rob_dp #(
    .MAX_W(MAX_W), .DEPTH(DEPTH), .UOP_W(UOP_W), .REG_W(REG_W),
    .PREG_W(PREG_W), .CFGW_W(CFGW_W), .IDX_W(IDX_W), .OCC_W(OCC_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .effWidth(effWidth),
    .cfgRegLimit(cfgRegLimit), .inUops(inUops), .inRegs(inRegs),
    .wbValid(wbValid), .wbTag(wbTag), .robUsed(robUsed), .regsUsed(regsInUse),
    .dispTag(dispTag), .retN(retN)
  );

  drc_stats #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .retN(retN),
    .stallCnt(stallCnt), .dispHist(dispHist), .retHist(retHist)
  );

  assign dispCount   = strobe.dispN;
  assign retireCount = retN;

endmodule

// File: tb/dispatch_retire_unit_test.sv
module dispatch_retire_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfgWidth;
  logic [6:0]  cfgRegLimit;
  logic [3:0]  inValid;
  logic [7:0]  inUops, inRegs, inKind;
  logic [3:0]  inSolo;
  logic [2:0]  schedFull;
  logic        lqFull, sqFull, wbValid;
  logic [3:0]  wbTag;
  logic [3:0]  dispCount, retireCount;
  logic [15:0] dispTag;
  logic [4:0]  robUsed;
  logic [6:0]  regsInUse;
  logic [95:0] stallCnt;
  logic [79:0] dispHist, retHist;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dispatch_retire_unit uut (
    .clk(clk), .rst_n(rst_n), .cfgWidth(cfgWidth), .cfgRegLimit(cfgRegLimit),
    .inValid(inValid), .inUops(inUops), .inRegs(inRegs), .inKind(inKind),
    .inSolo(inSolo), .schedFull(schedFull), .lqFull(lqFull), .sqFull(sqFull),
    .wbValid(wbValid), .wbTag(wbTag), .dispCount(dispCount), .dispTag(dispTag),
    .retireCount(retireCount), .robUsed(robUsed), .regsInUse(regsInUse),
    .stallCnt(stallCnt), .dispHist(dispHist), .retHist(retHist)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int stl(input int c);
    return int'(stallCnt[c*16 +: 16]);
  endfunction
  function automatic int dh(input int n);
    return int'(dispHist[n*16 +: 16]);
  endfunction
  function automatic int rh(input int n);
    return int'(retHist[n*16 +: 16]);
  endfunction
  function automatic int tagOf(input int k);
    return int'(dispTag[k*4 +: 4]);
  endfunction

  task automatic clearIn();
    inValid = '0; inUops = '0; inRegs = '0; inKind = '0; inSolo = '0;
    schedFull = '0; lqFull = 0; sqFull = 0; wbValid = 0; wbTag = '0;
  endtask

  task automatic setSlot(input int k, input int u, input int r, input int kd, input bit solo);
    inValid[k] = 1'b1;
    inUops[k*2 +: 2] = u[1:0];
    inRegs[k*2 +: 2] = r[1:0];
    inKind[k*2 +: 2] = kd[1:0];
    inSolo[k] = solo;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    rst_n = 0;
    clearIn();
    cfgWidth = '0;
    cfgRegLimit = '0;
    tick();
    tick();
    rst_n = 1;
  endtask

  task automatic testReset();
    doReset();
    #1;
    chk("R11 robUsed", int'(robUsed), 0);
    chk("R11 regsInUse", int'(regsInUse), 0);
    chk("R11 counters zero", int'(|stallCnt) + int'(|dispHist) + int'(|retHist), 0);
  endtask

  task automatic testWidth();
    doReset();
    for (int k = 0; k < 4; k++) setSlot(k, 1, 0, 0, 0);
    #1 chk("R2 default width", int'(dispCount), 2);
    chk("R1 tag of slot 1", tagOf(1), 1);
    cfgWidth = 3;
    #1 chk("R2 width 3", int'(dispCount), 3);
    cfgWidth = 7;
    #1 chk("R2 clamp to max", int'(dispCount), 4);
    inValid[2] = 1'b0;
    #1 chk("R1 stop at gap", int'(dispCount), 2);
  endtask

  task automatic testRob();
    doReset();
    cfgWidth = 4;
    for (int k = 0; k < 4; k++) setSlot(k, 3, 0, 0, 0);
    #1 chk("R3 four groups of 3", int'(dispCount), 4);
    chk("R3 tag of slot 3", tagOf(3), 9);
    tick();
    clearIn();
    setSlot(0, 3, 0, 0, 0);
    setSlot(1, 3, 0, 0, 0);
    setSlot(2, 1, 0, 0, 0);
    #1 chk("R3 robUsed 12", int'(robUsed), 12);
    chk("R3 no bypass of blocked slot", int'(dispCount), 1);
    tick();
    clearIn();
    #1 chk("R3 robUsed 15", int'(robUsed), 15);
    chk("R9 buffer stall counted", stl(1), 1);
    chk("R9 no register stall", stl(0), 0);
  endtask

  task automatic testRegs();
    doReset();
    cfgWidth = 4;
    cfgRegLimit = 3;
    setSlot(0, 1, 2, 0, 0);
    setSlot(1, 1, 2, 0, 0);
    #1 chk("R4 limit blocks second", int'(dispCount), 1);
    tick();
    clearIn();
    setSlot(0, 1, 1, 0, 0);
    #1 chk("R4 regsInUse 2", int'(regsInUse), 2);
    chk("R9 register stall", stl(0), 1);
    chk("R4 exact fit allowed", int'(dispCount), 1);
    tick();
    clearIn();
    #1 chk("R4 regsInUse 3", int'(regsInUse), 3);
    doReset();
    cfgWidth = 4;
    for (int k = 0; k < 4; k++) setSlot(k, 1, 3, 0, 0);
    #1 chk("R4 unlimited", int'(dispCount), 4);
  endtask

  task automatic testSched();
    doReset();
    cfgWidth = 4;
    schedFull = 3'b010;
    setSlot(0, 1, 0, 0, 0);
    setSlot(1, 1, 0, 1, 0);
    setSlot(2, 1, 0, 0, 0);
    #1 chk("R5 fp scheduler full", int'(dispCount), 1);
    tick();
    clearIn();
    lqFull = 1;
    setSlot(0, 1, 0, 2, 0);
    #1 chk("R9 scheduler stall", stl(2), 1);
    chk("R5 load blocked", int'(dispCount), 0);
    tick();
    clearIn();
    lqFull = 1;
    setSlot(0, 1, 0, 3, 0);
    #1 chk("R9 load queue stall", stl(3), 1);
    chk("R5 store ignores load queue", int'(dispCount), 1);
    tick();
    clearIn();
    sqFull = 1;
    setSlot(0, 1, 0, 3, 0);
    #1 chk("R5 store blocked", int'(dispCount), 0);
    tick();
    clearIn();
    #1 chk("R9 store queue stall", stl(4), 1);
  endtask

  task automatic testSolo();
    doReset();
    cfgWidth = 4;
    setSlot(0, 1, 0, 0, 0);
    setSlot(1, 1, 0, 0, 1);
    setSlot(2, 1, 0, 0, 0);
    #1 chk("R6 solo not in slot 1", int'(dispCount), 1);
    tick();
    clearIn();
    setSlot(0, 1, 0, 0, 1);
    setSlot(1, 1, 0, 0, 0);
    #1 chk("R6 solo alone", int'(dispCount), 1);
    tick();
    clearIn();
    #1 chk("R9 group stalls", stl(5), 2);
    doReset();
    cfgWidth = 4;
    cfgRegLimit = 1;
    setSlot(0, 1, 1, 0, 0);
    setSlot(1, 1, 1, 0, 1);
    #1 chk("R9 priority grant", int'(dispCount), 1);
    tick();
    clearIn();
    #1 chk("R9 register wins priority", stl(0), 1);
    chk("R9 group not counted", stl(5), 0);
  endtask

  task automatic testRetire();
    doReset();
    setSlot(0, 1, 1, 0, 0);
    setSlot(1, 1, 1, 0, 0);
    tick();
    clearIn();
    setSlot(0, 1, 1, 0, 0);
    #1 chk("R1 third tag", tagOf(0), 2);
    tick();
    clearIn();
    wbValid = 1; wbTag = 1;
    #1 chk("R8 regs allocated", int'(regsInUse), 3);
    chk("R7 nothing done", int'(retireCount), 0);
    tick();
    wbTag = 0;
    #1 chk("R7 younger done waits", int'(retireCount), 0);
    tick();
    wbValid = 0;
    #1 chk("R7 two retire in order", int'(retireCount), 2);
    tick();
    wbValid = 1; wbTag = 2;
    #1 chk("R8 regs released", int'(regsInUse), 1);
    chk("R8 slots released", int'(robUsed), 1);
    tick();
    wbValid = 0;
    #1 chk("R7 last retires", int'(retireCount), 1);
    tick();
    #1 chk("R8 empty", int'(robUsed) + int'(regsInUse), 0);
    doReset();
    cfgWidth = 4;
    setSlot(0, 3, 2, 1, 0);
    setSlot(1, 2, 1, 1, 0);
    #1 chk("R3 tag after 3 uops", tagOf(1), 3);
    tick();
    clearIn();
    wbValid = 1; wbTag = 3;
    tick();
    wbTag = 0;
    tick();
    wbValid = 0;
    #1 chk("R7 multi-uop retire", int'(retireCount), 2);
    tick();
    #1 chk("R8 multi-uop release", int'(robUsed) + int'(regsInUse), 0);
  endtask

  task automatic testHist();
    doReset();
    setSlot(0, 1, 0, 0, 0);
    setSlot(1, 1, 0, 0, 0);
    tick();
    clearIn();
    tick();
    setSlot(0, 1, 0, 0, 0);
    tick();
    clearIn();
    #1 chk("R10 bin 0", dh(0), 1);
    chk("R10 bin 1", dh(1), 1);
    chk("R10 bin 2", dh(2), 1);
    chk("R10 bin 3", dh(3), 0);
    chk("R10 retire bin 0", rh(0), 3);
  endtask

  initial begin
    testReset();
    testWidth();
    testRob();
    testRegs();
    testSched();
    testSolo();
    testRetire();
    testHist();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule